// File: doc/BRIEF.md
# Storage Key Guard

This block stands in front of a memory port and decides, for each access, whether it may go ahead. It holds a private table with one protection entry per 4 KB page frame. Each entry has a 4-bit access-control key and a fetch-protection flag. An access carries the requester's 4-bit key, which is taken from the key field of the running program's status word, and a read/write flag. The block compares the requester key with the key of the addressed frame. It then forwards the access on the memory side, or it drops the access and raises a protection program-check request.

The table can be reached only through a separate key port, which ordinary loads and stores cannot address. That port sets an entry or reads one back. Both key operations are privileged. If either is issued while the program is in problem state, it is refused and a privileged-operation check is raised instead. Every decision is registered, so its result appears one cycle after the request is accepted. When both ports request in the same cycle, the key port goes first. An access therefore always sees every key update made before it.

Top module: `skey_guard`

## Requirements
- R1: After reset every table entry is zero (key 0, fetch-protection flag 0), and `mem_req`, `prot_chk`, `key_done` and `priv_chk` are low.
- R2: The frame index of an access is `acc_addr[ADDR_W-1:12]`. Bits 11:0 do not affect the decision and are forwarded unchanged. A table entry is written and read as 5 bits, with the fetch-protection flag in bit 4 and the access-control key in bits 3:0.
- R3: The requester key is `cur_key`, and a requester key of 0 is allowed to both fetch and store any frame.
- R4: A store (`acc_write`=1) is allowed only when the requester key is 0 or equals the frame key.
- R5: A fetch (`acc_write`=0) is allowed when the requester key is 0, when it equals the frame key, or when the frame's fetch-protection flag is 0.
- R6: A denied access produces no `mem_req`. Instead `prot_chk` is high for exactly one cycle, one cycle after acceptance.
- R7: An allowed access produces a one-cycle `mem_req` pulse one cycle after acceptance. The pulse carries `mem_addr` equal to the accepted `acc_addr` and `mem_we` equal to `acc_write`.
- R8: A key request in supervisor state (`prob_state`=0) is answered by a one-cycle `key_done` pulse one cycle after it is accepted. A set (`key_set`=1) writes `key_wdata` to entry `key_frame`. An insert (`key_set`=0) returns that entry on `key_rdata`.
- R9: A key request in problem state (`prob_state`=1) changes no entry. It raises `priv_chk` together with `key_done`, and `key_rdata` reads 0.
- R10: `key_ready` is always 1, and `acc_ready` is 0 in any cycle where `key_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request accepted this cycle |
| acc_addr | input | ADDR_W | Access byte address |
| acc_write | input | 1 | 1 = store, 0 = fetch |
| cur_key | input | 4 | Requester key from the status word |
| prob_state | input | 1 | 1 = problem state, 0 = supervisor state |
| key_valid | input | 1 | Key port request valid |
| key_ready | output | 1 | Key port request accepted |
| key_set | input | 1 | 1 = set entry, 0 = insert (read) entry |
| key_frame | input | ADDR_W-12 | Frame index for the key port |
| key_wdata | input | 5 | Entry to write: {fetch-protect, key[3:0]} |
| key_done | output | 1 | Key request completed |
| key_rdata | output | 5 | Entry read by insert |
| priv_chk | output | 1 | Privileged-operation check |
| mem_req | output | 1 | Forwarded, allowed access |
| mem_addr | output | ADDR_W | Address of forwarded access |
| mem_we | output | 1 | Write flag of forwarded access |
| prot_chk | output | 1 | Protection check for a denied access |

## Verification
The assertions assume that `acc_valid` and `key_valid` are low while reset is held. They also assume that the requester key and the state flag are stable inside the cycle in which a request is accepted. Without these, the `$past` relations just after reset would see stray requests. The bench drives every input on the falling edge and holds all valids at zero during reset. It raises each request for exactly one accepting edge, so each result can be traced to one request.

// File: rtl/skey_guard.sv
module skey_guard #(
  parameter int ADDR_W      = 16,
  parameter int FRAME_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic [3:0]        cur_key,
  input  logic              prob_state,
  input  logic              key_valid,
  output logic              key_ready,
  input  logic              key_set,
  input  logic [ADDR_W-FRAME_SHIFT-1:0] key_frame,
  input  logic [4:0]        key_wdata,
  output logic              key_done,
  output logic [4:0]        key_rdata,
  output logic              priv_chk,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              prot_chk
);
  localparam int FIDX_W = ADDR_W - FRAME_SHIFT;
  localparam int FRAMES = 1 << FIDX_W;

  logic [4:0] keytab [FRAMES];

  logic [FIDX_W-1:0] acc_frame;
  logic [4:0]        entry;
  logic              match, allow;

  assign key_ready = 1'b1;
  assign acc_ready = !key_valid;

  assign acc_frame = acc_addr[ADDR_W-1:FRAME_SHIFT];
  assign entry     = keytab[acc_frame];
  assign match     = (cur_key == 4'd0) || (cur_key == entry[3:0]);
  assign allow     = acc_write ? match : (match || !entry[4]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < FRAMES; i++) keytab[i] <= '0;
      mem_req   <= 1'b0;
      prot_chk  <= 1'b0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      key_done  <= 1'b0;
      priv_chk  <= 1'b0;
      key_rdata <= '0;
    end else begin
      mem_req  <= 1'b0;
      prot_chk <= 1'b0;
      key_done <= 1'b0;
      priv_chk <= 1'b0;
      if (key_valid) begin
        key_done <= 1'b1;
        if (prob_state) begin
          priv_chk  <= 1'b1;
          key_rdata <= '0;
        end else if (key_set) begin
          keytab[key_frame] <= key_wdata;
          key_rdata <= '0;
        end else begin
          key_rdata <= keytab[key_frame];
        end
      end else if (acc_valid) begin
        mem_req  <= allow;
        prot_chk <= !allow;
        mem_addr <= acc_addr;
        mem_we   <= acc_write;
      end
    end
  end
endmodule

// File: rtl/skey_guard_chk.sv
module skey_guard_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_write,
  input logic [3:0]        cur_key,
  input logic              prob_state,
  input logic              key_valid,
  input logic              key_ready,
  input logic              key_done,
  input logic [4:0]        key_rdata,
  input logic              priv_chk,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              prot_chk
);
  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && prot_chk));

  assert_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || prot_chk) |-> $past(acc_valid && acc_ready));

  assert_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr == $past(acc_addr) && mem_we == $past(acc_write)));

  assert_key0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && cur_key == 4'd0) |=> mem_req);

  assert_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && key_ready) |=> key_done);

  assert_priv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && prob_state) |=> (priv_chk && key_rdata == 5'd0));

  assert_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> (!acc_ready && key_ready));
endmodule

bind skey_guard skey_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
  .acc_addr(acc_addr), .acc_write(acc_write), .cur_key(cur_key),
  .prob_state(prob_state), .key_valid(key_valid), .key_ready(key_ready),
  .key_done(key_done), .key_rdata(key_rdata), .priv_chk(priv_chk),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_we(mem_we), .prot_chk(prot_chk)
);

// File: tb/tb_skey_guard.sv
module tb_skey_guard;
  localparam int ADDR_W = 16;
  localparam int FW     = ADDR_W - 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0, prob_state = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [3:0] cur_key = '0;
  logic key_valid = 1'b0, key_set = 1'b0;
  logic [FW-1:0] key_frame = '0;
  logic [4:0] key_wdata = '0;
  logic acc_ready, key_ready, key_done, priv_chk, mem_req, mem_we, prot_chk;
  logic [4:0] key_rdata;
  logic [ADDR_W-1:0] mem_addr;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  skey_guard #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .acc_write(acc_write), .cur_key(cur_key),
    .prob_state(prob_state), .key_valid(key_valid), .key_ready(key_ready),
    .key_set(key_set), .key_frame(key_frame), .key_wdata(key_wdata),
    .key_done(key_done), .key_rdata(key_rdata), .priv_chk(priv_chk),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_we(mem_we), .prot_chk(prot_chk)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // fields: [21:20] kind (0 set, 1 fetch, 2 store, 3 insert), [19] problem,
  // [18:15] frame, [14:11] requester key, [10:6] wdata, [5] ok, [4:0] rdata
  localparam int NV = 18;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 1'b0, 4'd3,  4'd0,  5'h15, 1'b1, 5'h00},
    {2'd1, 1'b0, 4'd3,  4'd5,  5'h00, 1'b1, 5'h00},
    {2'd1, 1'b0, 4'd3,  4'd6,  5'h00, 1'b0, 5'h00},
    {2'd2, 1'b0, 4'd3,  4'd5,  5'h00, 1'b1, 5'h00},
    {2'd2, 1'b0, 4'd3,  4'd6,  5'h00, 1'b0, 5'h00},
    {2'd1, 1'b0, 4'd3,  4'd0,  5'h00, 1'b1, 5'h00},
    {2'd2, 1'b0, 4'd3,  4'd0,  5'h00, 1'b1, 5'h00},
    {2'd0, 1'b0, 4'd7,  4'd0,  5'h09, 1'b1, 5'h00},
    {2'd1, 1'b0, 4'd7,  4'd2,  5'h00, 1'b1, 5'h00},
    {2'd2, 1'b0, 4'd7,  4'd2,  5'h00, 1'b0, 5'h00},
    {2'd2, 1'b0, 4'd7,  4'd9,  5'h00, 1'b1, 5'h00},
    {2'd3, 1'b0, 4'd7,  4'd0,  5'h00, 1'b1, 5'h09},
    {2'd0, 1'b1, 4'd7,  4'd0,  5'h1F, 1'b0, 5'h00},
    {2'd3, 1'b0, 4'd7,  4'd0,  5'h00, 1'b1, 5'h09},
    {2'd3, 1'b1, 4'd3,  4'd0,  5'h00, 1'b0, 5'h00},
    {2'd2, 1'b0, 4'd0,  4'd15, 5'h00, 1'b0, 5'h00},
    {2'd1, 1'b0, 4'd0,  4'd15, 5'h00, 1'b1, 5'h00},
    {2'd3, 1'b0, 4'd15, 4'd0,  5'h00, 1'b1, 5'h00}
  };

  task automatic key_op(input logic set, input logic prob, input logic [FW-1:0] fr, input logic [4:0] wd);
    @(negedge clk);
    key_valid = 1'b1; key_set = set; prob_state = prob; key_frame = fr; key_wdata = wd;
    @(negedge clk);
    key_valid = 1'b0; prob_state = 1'b0;
  endtask

  task automatic acc_op(input logic wr, input logic [3:0] k, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; cur_key = k; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "mem_req in reset", mem_req, 0);
    chk("R1", "prot_chk in reset", prot_chk, 0);
    chk("R1", "key_done in reset", key_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "priv_chk after reset", priv_chk, 0);
    chk("R10", "key_ready idle", key_ready, 1);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] kind;
      logic [ADDR_W-1:0] a;
      kind = VEC[i][21:20];
      a = {VEC[i][18:15], 12'hA5C};
      if (kind == 2'd1 || kind == 2'd2) begin
        acc_op(kind == 2'd2, VEC[i][14:11], a);
        if (kind == 2'd2) chk("R4", "store mem_req", mem_req, VEC[i][5]);
        else              chk("R5", "fetch mem_req", mem_req, VEC[i][5]);
        chk("R6", "prot_chk", prot_chk, !VEC[i][5]);
        if (VEC[i][5]) begin
          chk("R7", "mem_addr", mem_addr, a);
          chk("R7", "mem_we", mem_we, kind == 2'd2);
        end
        if (VEC[i][14:11] == 4'd0) chk("R3", "key 0 allowed", mem_req, 1);
        if (VEC[i][18:15] == 4'd0) chk("R1", "reset entry decision", mem_req, VEC[i][5]);
      end else begin
        key_op(kind == 2'd0, VEC[i][19], VEC[i][18:15], VEC[i][10:6]);
        chk("R8", "key_done", key_done, 1);
        chk("R9", "priv_chk", priv_chk, !VEC[i][5]);
        if (kind == 2'd3) chk("R2", "insert rdata", key_rdata, VEC[i][4:0]);
      end
    end

    // R7/R6: pulses last a single cycle
    acc_op(1'b0, 4'd5, 16'h3000);
    chk("R7", "pulse present", mem_req, 1);
    @(negedge clk);
    chk("R7", "pulse one cycle", mem_req, 0);
    acc_op(1'b1, 4'd6, 16'h3FFF);
    chk("R6", "denied pulse", prot_chk, 1);
    @(negedge clk);
    chk("R6", "denied one cycle", prot_chk, 0);

    // R10: key port wins over a simultaneous access; access then sees new key
    @(negedge clk);
    key_valid = 1'b1; key_set = 1'b1; prob_state = 1'b0; key_frame = 4'd5; key_wdata = 5'h14;
    acc_valid = 1'b1; acc_write = 1'b1; cur_key = 4'd4; acc_addr = 16'h5123;
    #1 chk("R10", "acc_ready while key_valid", acc_ready, 0);
    @(negedge clk);
    chk("R10", "key done first", key_done, 1);
    chk("R10", "no access result yet", mem_req | prot_chk, 0);
    key_valid = 1'b0;
    #1 chk("R10", "acc_ready restored", acc_ready, 1);
    @(negedge clk);
    acc_valid = 1'b0;
    chk("R4", "store after new key", mem_req, 1);
    acc_op(1'b0, 4'd3, 16'h5000);
    chk("R5", "fetch-protected other key", prot_chk, 1);

    // R2: low address bits do not select the frame
    acc_op(1'b1, 4'd4, 16'h5FFF);
    chk("R2", "low bits ignored", mem_req, 1);
    acc_op(1'b1, 4'd4, 16'h6000);
    chk("R2", "next frame differs", prot_chk, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule